// File: doc/BRIEF.md
# GPIO Interrupt Controller

This block manages seven general-purpose pins and one shared active-low host interrupt. Each pin has a direction bit and an output-value bit that drive the pad enable and pad data. When a pin is an input, its level first passes through a two-flop synchronizer. The synchronized level then feeds a per-pin detector that can be set to level sensitivity or to rising-edge sensitivity.

Each detector reports into a status bit. A per-pin enable mask decides whether that bit may pull the shared interrupt line low. Software reaches every register through a simple single-cycle read/write bus. Reading the status register returns the latched events and clears the edge-captured ones. Level-captured bits stay set for as long as the pin stays high.

Register map: address 0 is direction (1 = output), 1 is output value, 2 is trigger select (0 = level, 1 = rising edge), 3 is interrupt enable mask (1 = enabled), 4 is status (read-only, cleared on read for edge pins), and 5 is the synchronized pin levels (read-only). Bit i of each register belongs to pin i. Reads return the register in bits 6:0, with bit 7 zero.

Top module: `gpio_irq_top`

## Requirements
- R1: After reset, every pin is an input (`pinOe` = 0) and `pinOut` = 0. The trigger, mask and status registers are all 0, and `irqN` is high.
- R2: Direction (address 0) and output value (address 1) are written from `busWrData[6:0]` and drive `pinOe` and `pinOut` directly. Reading either address returns the stored value zero-extended, so writing 0xFF reads back as 0x7F.
- R3: A pin change passes through two synchronizer flops. A status bit therefore changes on the third rising clock edge after the pin changes, and not earlier.
- R4: In edge mode (trigger bit 1), a rising edge of the synchronized pin sets the status bit. The bit stays set after the pin falls.
- R5: In level mode (trigger bit 0), the status bit is 1 while the synchronized pin is high and 0 while it is low. A status read does not clear it.
- R6: A read of address 4 returns the status as it was before the read edge, and clears the edge-mode bits at that edge. A rising edge detected in the same cycle as the read still sets its bit.
- R7: `irqN` is low exactly when some pin has both its status bit and its mask bit at 1.
- R8: A pin whose mask bit is 0 still records status, and that status can be read. It does not pull `irqN` low.
- R9: A pin configured as an output (direction bit 1) records no status.
- R10: A read of address 5 returns the synchronized pin levels.
- R11: Reads of addresses 6 and 7 return 0. Writes to addresses 4 to 7 change no state. Read data is registered: it updates on the edge where `busRdEn` is sampled and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdEn | input | 1 | Read strobe, one cycle per read |
| busAddr | input | 3 | Register address |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Registered read data |
| pinIn | input | 7 | Asynchronous pin levels from the pads |
| pinOut | output | 7 | Pad output values |
| pinOe | output | 7 | Pad output enables (1 = output) |
| irqN | output | 1 | Shared active-low interrupt |

## Verification
The bench targets a race between a status read and an edge that arrives in the same cycle. A design that lets the clear win would silently lose that interrupt. It counts the cycles through the synchronizer, so a design with a missing or extra flop reports one edge early or late. It checks that reading a level-mode bit does not clear it, since a design that clears it would drop `irqN` while the pin is still high. It also checks that masked pins and output pins behave correctly: a masked pin that pulls `irqN` low, or an output pin that records status, is caught at the ports.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_DIR  = 3'd0,
    REG_OUT  = 3'd1,
    REG_TRIG = 3'd2,
    REG_MASK = 3'd3,
    REG_STAT = 3'd4,
    REG_PIN  = 3'd5,
    REG_RSV6 = 3'd6,
    REG_RSV7 = 3'd7
  } regSel_e;

  // strobes from the bus control to the datapath
  typedef struct packed {
    logic    wrDir;
    logic    wrOut;
    logic    wrTrig;
    logic    wrMask;
    logic    rdEn;
    logic    rdStat;
    regSel_e rdSel;
  } ctlStrobe_t;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH  = 7,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] stageQ;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[0] <= '0;
        else       stageQ[0] <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ <= '0;
        else       stageQ <= {stageQ[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = stageQ[STAGES-1];

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
(
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output ctlStrobe_t        strb
);

  regSel_e sel;

  always_comb begin
    sel         = regSel_e'(busAddr);
    strb        = '0;
    strb.rdSel  = sel;
    strb.rdEn   = busRdEn;
    strb.rdStat = busRdEn && (sel == REG_STAT);
    if (busWrEn) begin
      unique case (sel)
        REG_DIR:  strb.wrDir  = 1'b1;
        REG_OUT:  strb.wrOut  = 1'b1;
        REG_TRIG: strb.wrTrig = 1'b1;
        REG_MASK: strb.wrMask = 1'b1;
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/gpio_irq_dp.sv
module gpio_irq_dp
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          strb,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [DATA_W-1:0]   rdData,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic                irqN
);

  logic [NUM_PINS-1:0] dirQ, outQ, trigQ, maskQ, statQ;
  logic [NUM_PINS-1:0] syncPin, prevPin, rise, statNext, wrBits;
  logic [NUM_PINS-1:0] rdBits;
  logic [DATA_W-1:0]   rdWide;

  assign wrBits = wrData[NUM_PINS-1:0];

  gpio_irq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (pinIn),
    .dout (syncPin)
  );

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ  <= '0;
      outQ  <= '0;
      trigQ <= '0;
      maskQ <= '0;
    end else begin
      if (strb.wrDir)  dirQ  <= wrBits;
      if (strb.wrOut)  outQ  <= wrBits;
      if (strb.wrTrig) trigQ <= wrBits;
      if (strb.wrMask) maskQ <= wrBits;
    end
  end

  // detection
  assign rise = syncPin & ~prevPin;

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) begin
      if (dirQ[i])       statNext[i] = 1'b0;
      else if (trigQ[i]) statNext[i] = rise[i] | (statQ[i] & ~strb.rdStat);
      else               statNext[i] = syncPin[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevPin <= '0;
      statQ   <= '0;
    end else begin
      prevPin <= syncPin;
      statQ   <= statNext;
    end
  end

  // read path
  always_comb begin
    unique case (strb.rdSel)
      REG_DIR:  rdBits = dirQ;
      REG_OUT:  rdBits = outQ;
      REG_TRIG: rdBits = trigQ;
      REG_MASK: rdBits = maskQ;
      REG_STAT: rdBits = statQ;
      REG_PIN:  rdBits = syncPin;
      default:  rdBits = '0;
    endcase
    rdWide                 = '0;
    rdWide[NUM_PINS-1:0]   = rdBits;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdData <= '0;
    else if (strb.rdEn) rdData <= rdWide;
  end

  assign pinOut = outQ;
  assign pinOe  = dirQ;
  assign irqN   = ~|(statQ & maskQ);

  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
      AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rstN) (trigQ[i] && !dirQ[i] && rise[i]) |=> statQ[i]); // R4
      AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rstN) (trigQ[i] && !dirQ[i] && statQ[i] && !strb.rdStat) |=> statQ[i]); // R4
      AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rstN) (strb.rdStat && trigQ[i] && !dirQ[i] && !rise[i]) |=> !statQ[i]); // R6
      AST_LEVEL_DROP: assert property (@(posedge clk) disable iff (!rstN) (!trigQ[i] && !dirQ[i] && !syncPin[i]) |=> !statQ[i]); // R5
      AST_OUTPUT_QUIET: assert property (@(posedge clk) disable iff (!rstN) dirQ[i] |=> !statQ[i]); // R9
    end
  endgenerate

endmodule

// File: rtl/gpio_irq_top.sv
module gpio_irq_top
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic                busRdEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWrData,
  output logic [DATA_W-1:0]   busRdData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic                irqN
);

  ctlStrobe_t strb;

  gpio_irq_ctrl u_ctrl (
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .busAddr (busAddr),
    .strb    (strb)
  );

  gpio_irq_dp #(
    .NUM_PINS    (NUM_PINS),
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (busWrData),
    .pinIn  (pinIn),
    .rdData (busRdData),
    .pinOut (pinOut),
    .pinOe  (pinOe),
    .irqN   (irqN)
  );

endmodule

// File: tb/test_gpio_irq_top.sv
`timescale 1ns/1ps
module test_gpio_irq_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWrEn = 1'b0;
  logic       busRdEn = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic [6:0] pinIn = '0;
  logic [6:0] pinOut;
  logic [6:0] pinOe;
  logic       irqN;

  int  testCount = 0;
  int  failCount = 0;
  bit  finished  = 0;

  always #2.5 clk = ~clk;

  gpio_irq_top i_gpio_irq_top (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .irqN(irqN)
  );

  // {trig, mask, pulse, hold}, 7 bits each
  localparam logic [27:0] VEC [8] = '{
    {7'h7F, 7'h7F, 7'h01, 7'h00},
    {7'h00, 7'h7F, 7'h02, 7'h00},
    {7'h00, 7'h7F, 7'h00, 7'h04},
    {7'h7F, 7'h00, 7'h55, 7'h00},
    {7'h0F, 7'h70, 7'h0F, 7'h30},
    {7'h70, 7'h0F, 7'h40, 7'h03},
    {7'h2A, 7'h2A, 7'h00, 7'h00},
    {7'h7F, 7'h40, 7'h3F, 7'h40}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic setPins(input logic [6:0] v);
    @(negedge clk);
    pinIn = v;
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    @(posedge clk); #1;
    d = busRdData;
    busRdEn = 1'b0;
  endtask

  function automatic logic [6:0] expStatus(input logic [6:0] trig, pulse, hold);
    return (trig & (pulse | hold)) | (~trig & hold);
  endfunction

  task automatic quiesce();
    logic [7:0] d;
    setPins(7'h00);
    waitCyc(4);
    busRead(3'd4, d);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    testCount++;
    failCount++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish();
  end

  initial begin
    logic [7:0] d;
    logic [6:0] st;

    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1;

    // R1 reset state
    check("R1 pinOe", {1'b0, pinOe}, 8'h00);
    check("R1 pinOut", {1'b0, pinOut}, 8'h00);
    check("R1 irqN", {7'h0, irqN}, 8'h01);
    for (int a = 0; a < 5; a++) begin
      busRead(3'(a), d);
      check("R1 register", d, 8'h00);
    end

    // table walk: R4 R5 R7 R8
    for (int v = 0; v < 8; v++) begin
      quiesce();
      busWrite(3'd2, {1'b0, VEC[v][27:21]});
      busWrite(3'd3, {1'b0, VEC[v][20:14]});
      setPins(VEC[v][13:7]);
      waitCyc(4);
      setPins(VEC[v][6:0]);
      waitCyc(4);
      st = expStatus(VEC[v][27:21], VEC[v][13:7], VEC[v][6:0]);
      check("R7 R8 irqN", {7'h0, irqN}, {7'h0, ~|(st & VEC[v][20:14])});
      busRead(3'd4, d);
      check("R4 R5 status", d, {1'b0, st});
    end

    // R2 direction and output registers
    quiesce();
    busWrite(3'd0, 8'hFF);
    busRead(3'd0, d);
    check("R2 dir width", d, 8'h7F);
    busWrite(3'd0, 8'h5A);
    busWrite(3'd1, 8'h33);
    check("R2 pinOe", {1'b0, pinOe}, 8'h5A);
    check("R2 pinOut", {1'b0, pinOut}, 8'h33);
    busRead(3'd1, d);
    check("R2 out readback", d, 8'h33);

    // R9 output pins record nothing
    busWrite(3'd2, 8'h7F);
    busWrite(3'd3, 8'h7F);
    busRead(3'd4, d);
    setPins(7'h7F);
    waitCyc(4);
    busRead(3'd4, d);
    check("R9 status", d, 8'h25);
    quiesce();
    busWrite(3'd0, 8'h00);
    busWrite(3'd1, 8'h00);

    // R3 synchronizer latency
    busWrite(3'd2, 8'h01);
    busWrite(3'd3, 8'h01);
    quiesce();
    setPins(7'h01);
    @(posedge clk); #1;
    check("R3 edge1", {7'h0, irqN}, 8'h01);
    @(posedge clk); #1;
    check("R3 edge2", {7'h0, irqN}, 8'h01);
    @(posedge clk); #1;
    check("R3 edge3", {7'h0, irqN}, 8'h00);

    // R6 read clears, and pin held high does not relatch
    busRead(3'd4, d);
    check("R6 read value", d, 8'h01);
    check("R6 irq after clear", {7'h0, irqN}, 8'h01);
    busRead(3'd4, d);
    check("R6 no relatch", d, 8'h00);

    // R6 edge arriving on the read edge survives
    quiesce();
    setPins(7'h01);
    @(posedge clk);
    @(posedge clk);
    busRead(3'd4, d);
    check("R6 race read", d, 8'h00);
    check("R6 race irq", {7'h0, irqN}, 8'h00);
    busRead(3'd4, d);
    check("R6 race kept", d, 8'h01);

    // R5 level bit is not cleared by reading
    quiesce();
    busWrite(3'd2, 8'h00);
    busWrite(3'd3, 8'h02);
    setPins(7'h02);
    waitCyc(4);
    busRead(3'd4, d);
    check("R5 level read1", d, 8'h02);
    busRead(3'd4, d);
    check("R5 level read2", d, 8'h02);
    check("R5 level irq", {7'h0, irqN}, 8'h00);
    setPins(7'h00);
    waitCyc(3);
    check("R5 level irq drop", {7'h0, irqN}, 8'h01);
    busRead(3'd4, d);
    check("R5 level cleared", d, 8'h00);

    // R10 pin register
    setPins(7'h2D);
    waitCyc(3);
    busRead(3'd5, d);
    check("R10 pins", d, 8'h2D);

    // R11 reserved reads and ignored writes
    quiesce();
    busWrite(3'd2, 8'h7F);
    busWrite(3'd3, 8'h00);
    setPins(7'h01);
    waitCyc(4);
    busWrite(3'd4, 8'h00);
    busWrite(3'd6, 8'h7F);
    busWrite(3'd7, 8'h7F);
    busRead(3'd6, d);
    check("R11 addr6", d, 8'h00);
    check("R11 rdData holds", busRdData, 8'h00);
    busRead(3'd7, d);
    check("R11 addr7", d, 8'h00);
    busRead(3'd4, d);
    check("R11 status kept", d, 8'h01);
    busRead(3'd3, d);
    check("R11 mask kept", d, 8'h00);
    check("R11 pinOe kept", {1'b0, pinOe}, 8'h00);

    finish();
  end

endmodule